// File: doc/BRIEF.md
# SPI Master Shift Engine (Clock Phase 1)

This block moves words serially to and from one SPI slave, acting as master. Software writes a word into the transmit port. The engine lowers slave select and waits a programmed leading time. It then produces the serial clock and swaps the word with the slave. After the last bit it places the received word in a separate receive register and raises a completion flag. It honours a programmed trailing time after the last clock edge and a programmed idle time between transfers.

The clock phase is fixed. Outgoing data moves on the first clock edge of each bit, and incoming data is taken on the second edge. Configuration inputs select:
- the idle level of the serial clock;
- the bit order;
- 8-bit or 16-bit words;
- whether slave select is driven at all;
- the clock divider.

A word written while a transfer is running waits in a one-entry buffer. It starts as soon as the trailing time ends. Slave select stays low, and the leading and idle times are skipped.

Top module: `spiMaster`

## Requirements
- R1: A transfer moves n bits, where n is 16 when `cfgWide`=1 and 8 when `cfgWide`=0, using exactly 2n serial clock edges.
- R2: Edges are numbered from 1. On every odd edge `mosi` takes the next outgoing bit; edge 1 presents the first bit. `mosi` holds its value at all other times. `miso` is sampled on every even edge.
- R3: With `cfgLsbFirst`=0 bits travel most significant first, and with `cfgLsbFirst`=1 least significant first. The same order applies in both directions.
- R4: `rxData` changes only in the cycle after edge 2n, when it takes the whole received word. In 8-bit mode bits 15:8 of `rxData` read 0.
- R5: `doneFlag` rises with the `rxData` update. It clears in the cycle after a cycle with `rxRead`=1, unless a new word lands in that same cycle.
- R6: If a word lands while `doneFlag` is 1 and `rxRead` is 0, `overrun` becomes 1 and `rxData` is still overwritten. A read clears `overrun`.
- R7: `sck` equals `cfgCpol` whenever no transfer is clocking. Each numbered edge toggles it.
- R8: A `txWrite` sampled at clock edge P0 with the engine idle lowers `ssN` after edge P1. Numbered edge k then happens at P(cfgLead+2+k*(cfgHalf+1)), so one half period is cfgHalf+1 clocks.
- R9: After edge 2n the engine waits max(cfgTrail,cfgHalf)+1 clocks, then raises `ssN`. It then stays idle for cfgIdle+2 clocks before any new start can lower `ssN`.
- R10: A word written during a transfer starts the next transfer at the end of the trailing time. `ssN` stays low throughout, and edge 1 of the new word follows cfgHalf+1 clocks later.
- R11: With `cfgAutoSs`=0, `ssN` stays 1 while transfers run normally.
- R12: After reset the outputs are `sck`=`cfgCpol`, `ssN`=1, `mosi`=0, `doneFlag`=0, `overrun`=0, `rxData`=0 and `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgCpol | input | 1 | Serial clock idle level |
| cfgLsbFirst | input | 1 | 1 = least significant bit first |
| cfgWide | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| cfgAutoSs | input | 1 | 1 = drive slave select automatically |
| cfgHalf | input | 8 | Half serial clock period minus one, in clocks |
| cfgLead | input | 8 | Leading time setting |
| cfgTrail | input | 8 | Trailing time setting |
| cfgIdle | input | 8 | Idle time setting |
| txWrite | input | 1 | Write strobe for the transmit word |
| txData | input | 16 | Transmit word |
| rxRead | input | 1 | Read strobe, clears the flags |
| miso | input | 1 | Serial data from the slave |
| rxData | output | 16 | Receive register |
| doneFlag | output | 1 | Transfer complete flag |
| overrun | output | 1 | Unread word was overwritten |
| busy | output | 1 | Transfer running or pending |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ssN | output | 1 | Slave select, active low |

## Verification
Every result has a fixed cycle offset from its stimulus:
- `ssN` falls one clock after the write is sampled.
- Edge k lands cfgLead+2+k*(cfgHalf+1) clocks after the write.
- `rxData` and `doneFlag` change one clock after edge 2n.
- The flags clear one clock after a read.
- `ssN` rises max(cfgTrail,cfgHalf)+1 clocks after edge 2n.

The bench model waits out these same clock counts on rising edges. It then compares `sck`, `ssN`, `mosi`, `busy`, `rxData` and both flags with the design at every falling edge, so a result that is one cycle early or late is caught. A slave model exchanges words with the engine across both polarities, both orders and both widths.

// File: rtl/spiPkg.sv
`timescale 1ns/1ps
package spiPkg;

  // Per-cycle commands from the sequencer to the datapath
  typedef struct packed {
    logic load;     // copy transmit buffer into the shift register
    logic sample;   // latch miso (even edge)
    logic shift;    // advance shift register (odd edge or final edge)
    logic useMiso;  // shift in miso directly instead of the latched bit
    logic present;  // update mosi with the next outgoing bit
    logic capture;  // move finished word into the receive register
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_XFER  = 3'd2,
    ST_TRAIL = 3'd3,
    ST_GAP   = 3'd4
  } seqState_t;

endpackage

// File: rtl/spiCtrl.sv
`timescale 1ns/1ps
module spiCtrl
  import spiPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  parameter int DLY_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWide,
  input  logic             cfgAutoSs,
  input  logic [DIV_W-1:0] cfgHalf,
  input  logic [DLY_W-1:0] cfgLead,
  input  logic [DLY_W-1:0] cfgTrail,
  input  logic [DLY_W-1:0] cfgIdle,
  input  logic             txPend,
  output strobe_t          strb,
  output logic             sckRaw,
  output logic             ssN,
  output logic             busy
);

  localparam int EDGE_W = $clog2(2 * DATA_W + 1);
  localparam int CNT_W  = (DLY_W > DIV_W) ? DLY_W : DIV_W;

  seqState_t         state;
  logic [CNT_W-1:0]  dlyCnt;
  logic [DIV_W-1:0]  divCnt;
  logic [EDGE_W-1:0] edgeCnt;

  logic [EDGE_W-1:0] lastEdge;
  logic [EDGE_W-1:0] nextEdge;
  logic [CNT_W-1:0]  trailLen;
  logic              edgeNow;
  logic              dlyDone;

  assign lastEdge = cfgWide ? EDGE_W'(2 * DATA_W) : EDGE_W'(DATA_W);
  assign nextEdge = edgeCnt + EDGE_W'(1);
  assign edgeNow  = (state == ST_XFER) && (divCnt == cfgHalf);
  assign dlyDone  = (dlyCnt == '0);
  assign trailLen = (CNT_W'(cfgTrail) > CNT_W'(cfgHalf)) ? CNT_W'(cfgTrail)
                                                         : CNT_W'(cfgHalf);
  assign busy     = (state != ST_IDLE) || txPend;

  always_comb begin
    strb = '0;
    strb.load = txPend && ((state == ST_IDLE) ||
                           ((state == ST_TRAIL) && dlyDone));
    if (edgeNow) begin
      if (nextEdge[0]) begin
        strb.present = 1'b1;
        strb.shift   = (nextEdge != EDGE_W'(1));
      end else if (nextEdge == lastEdge) begin
        strb.shift   = 1'b1;
        strb.useMiso = 1'b1;
        strb.capture = 1'b1;
      end else begin
        strb.sample  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      dlyCnt  <= '0;
      divCnt  <= '0;
      edgeCnt <= '0;
      sckRaw  <= 1'b0;
      ssN     <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (txPend) begin
            state  <= ST_LEAD;
            dlyCnt <= CNT_W'(cfgLead);
            ssN    <= !cfgAutoSs;
          end
        end
        ST_LEAD: begin
          if (dlyDone) begin
            state   <= ST_XFER;
            divCnt  <= '0;
            edgeCnt <= '0;
          end else begin
            dlyCnt <= dlyCnt - CNT_W'(1);
          end
        end
        ST_XFER: begin
          if (edgeNow) begin
            divCnt  <= '0;
            edgeCnt <= nextEdge;
            sckRaw  <= ~sckRaw;
            if (nextEdge == lastEdge) begin
              state  <= ST_TRAIL;
              dlyCnt <= trailLen;
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_TRAIL: begin
          if (dlyDone) begin
            if (txPend) begin
              state   <= ST_XFER;
              divCnt  <= '0;
              edgeCnt <= '0;
            end else begin
              state  <= ST_GAP;
              dlyCnt <= CNT_W'(cfgIdle);
              ssN    <= 1'b1;
            end
          end else begin
            dlyCnt <= dlyCnt - CNT_W'(1);
          end
        end
        ST_GAP: begin
          if (dlyDone) state <= ST_IDLE;
          else         dlyCnt <= dlyCnt - CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: the clock is back at its idle level whenever not shifting
  p_sck_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_XFER) |-> !sckRaw);

  // R1: never more than 2n edges in one word
  p_edge_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_XFER) |-> (edgeCnt < lastEdge));

  // R8: select is low while clocking when automatic select is on
  p_ss_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_XFER && cfgAutoSs) |-> !ssN);

  // R10: a pending word chains straight into shifting, select unchanged
  p_chain_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TRAIL && dlyDone && txPend) |=> (state == ST_XFER && $stable(ssN)));

endmodule

// File: rtl/spiData.sv
`timescale 1ns/1ps
module spiData
  import spiPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWide,
  input  logic              cfgLsbFirst,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRead,
  input  logic              miso,
  input  strobe_t           strb,
  output logic              txPend,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData,
  output logic              doneFlag,
  output logic              overrun
);

  localparam int HALF_W = DATA_W / 2;
  localparam int IDX_W  = $clog2(DATA_W);

  logic [DATA_W-1:0] txBuf;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] shiftNext;
  logic [DATA_W-1:0] shiftUse;
  logic [DATA_W-1:0] widthMask;
  logic [DATA_W-1:0] inVec;
  logic [IDX_W-1:0]  topIdx;
  logic              sampBit;
  logic              inBit;
  logic              outBit;

  assign widthMask = cfgWide ? {DATA_W{1'b1}}
                             : {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  assign topIdx    = cfgWide ? IDX_W'(DATA_W - 1) : IDX_W'(HALF_W - 1);
  assign inBit     = strb.useMiso ? miso : sampBit;

  always_comb begin
    inVec         = '0;
    inVec[topIdx] = inBit;
    if (cfgLsbFirst)
      shiftNext = (shiftReg >> 1) | inVec;
    else
      shiftNext = ((shiftReg << 1) | {{(DATA_W-1){1'b0}}, inBit}) & widthMask;
    shiftUse = strb.shift ? shiftNext : shiftReg;
    outBit   = cfgLsbFirst ? shiftUse[0] : shiftUse[topIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf    <= '0;
      txPend   <= 1'b0;
      shiftReg <= '0;
      sampBit  <= 1'b0;
      mosi     <= 1'b0;
      rxData   <= '0;
      doneFlag <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (txWrite) begin
        txBuf  <= txData;
        txPend <= 1'b1;
      end else if (strb.load) begin
        txPend <= 1'b0;
      end

      if (strb.load)       shiftReg <= txBuf & widthMask;
      else if (strb.shift) shiftReg <= shiftNext;

      if (strb.sample)  sampBit <= miso;
      if (strb.present) mosi    <= outBit;

      if (strb.capture) begin
        rxData   <= shiftNext;
        doneFlag <= 1'b1;
        if (doneFlag && !rxRead) overrun <= 1'b1;
        else if (rxRead)         overrun <= 1'b0;
      end else if (rxRead) begin
        doneFlag <= 1'b0;
        overrun  <= 1'b0;
      end
    end
  end

  // R5: a landed word always leaves the flag set
  p_flag_on_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> doneFlag);

  // R4: receive register only moves when a word lands
  p_rx_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(rxData));

  // R2: serial output only moves on odd edges
  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.present |=> $stable(mosi));

  // R6: overrun rises only when a word lands on an unread one
  p_ovr_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(doneFlag && strb.capture && !rxRead));

endmodule

// File: rtl/spiMaster.sv
`timescale 1ns/1ps
module spiMaster
  import spiPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgCpol,
  input  logic              cfgLsbFirst,
  input  logic              cfgWide,
  input  logic              cfgAutoSs,
  input  logic [DIV_W-1:0]  cfgHalf,
  input  logic [DLY_W-1:0]  cfgLead,
  input  logic [DLY_W-1:0]  cfgTrail,
  input  logic [DLY_W-1:0]  cfgIdle,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRead,
  input  logic              miso,
  output logic [DATA_W-1:0] rxData,
  output logic              doneFlag,
  output logic              overrun,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              ssN
);

  strobe_t strb;
  logic    txPend;
  logic    sckRaw;

  spiCtrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .DLY_W(DLY_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWide   (cfgWide),
    .cfgAutoSs (cfgAutoSs),
    .cfgHalf   (cfgHalf),
    .cfgLead   (cfgLead),
    .cfgTrail  (cfgTrail),
    .cfgIdle   (cfgIdle),
    .txPend    (txPend),
    .strb      (strb),
    .sckRaw    (sckRaw),
    .ssN       (ssN),
    .busy      (busy)
  );

  spiData #(.DATA_W(DATA_W)) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWide     (cfgWide),
    .cfgLsbFirst (cfgLsbFirst),
    .txWrite     (txWrite),
    .txData      (txData),
    .rxRead      (rxRead),
    .miso        (miso),
    .strb        (strb),
    .txPend      (txPend),
    .mosi        (mosi),
    .rxData      (rxData),
    .doneFlag    (doneFlag),
    .overrun     (overrun)
  );

  assign sck = sckRaw ^ cfgCpol;

endmodule

// File: tb/spiMaster_bench.sv
`timescale 1ns/1ps
module spiMaster_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgCpol = 1'b0, cfgLsbFirst = 1'b0, cfgWide = 1'b0, cfgAutoSs = 1'b1;
  logic [7:0]  cfgHalf = 8'd1, cfgLead = 8'd0, cfgTrail = 8'd0, cfgIdle = 8'd0;
  logic        txWrite = 1'b0;
  logic [15:0] txData = '0;
  logic        rxRead = 1'b0;
  logic        miso = 1'b0;
  logic [15:0] rxData;
  logic        doneFlag, overrun, busy, sck, mosi, ssN;

  always #4 clk = ~clk;

  spiMaster u_spiMaster (
    .clk(clk), .rstN(rstN), .cfgCpol(cfgCpol), .cfgLsbFirst(cfgLsbFirst),
    .cfgWide(cfgWide), .cfgAutoSs(cfgAutoSs), .cfgHalf(cfgHalf),
    .cfgLead(cfgLead), .cfgTrail(cfgTrail), .cfgIdle(cfgIdle),
    .txWrite(txWrite), .txData(txData), .rxRead(rxRead), .miso(miso),
    .rxData(rxData), .doneFlag(doneFlag), .overrun(overrun), .busy(busy),
    .sck(sck), .mosi(mosi), .ssN(ssN)
  );

  int checks = 0;
  int fails  = 0;
  bit cmpOn  = 0;
  bit slaveOn = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model state ----------------
  logic [15:0] pendQ[$];
  logic [15:0] mSlaveQ[$];
  logic [15:0] slaveQ[$];
  logic [15:0] masterQ[$];
  logic [15:0] slaveRxQ[$];
  logic        expSckRaw = 0, expSsN = 1, expMosi = 0, expDone = 0, expOvr = 0;
  logic [15:0] expRx = '0;
  bit          mBusy = 0;
  int          capCount = 0;
  int          lastCap = 0;
  logic [15:0] pw;
  bit          rdNow;

  always @(posedge clk) begin
    if (txWrite && rstN) begin
      pw = txData;
      #2;
      pendQ.push_back(pw);
    end
  end

  always @(posedge clk) begin
    rdNow = rxRead;
    #3;
    if (capCount != lastCap) begin
      lastCap = capCount;
      if (expDone && !rdNow) expOvr = 1;
      else if (rdNow)        expOvr = 0;
      expDone = 1;
    end else if (rdNow) begin
      expDone = 0;
      expOvr  = 0;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin : model
    logic [15:0] w;
    int n, trail;
    bit more;
    wait (rstN);
    forever begin
      tick();
      if (pendQ.size() > 0) begin
        w = pendQ.pop_front();
        mBusy = 1;
        if (cfgAutoSs) expSsN = 0;
        repeat (int'(cfgLead) + 1) tick();
        more = 1;
        while (more) begin
          n = cfgWide ? 16 : 8;
          for (int k = 1; k <= 2 * n; k++) begin
            repeat (int'(cfgHalf) + 1) tick();
            expSckRaw = ~expSckRaw;
            if (k % 2 == 1)
              expMosi = cfgLsbFirst ? w[(k-1)/2] : w[n-1-(k-1)/2];
            if (k == 2 * n) begin
              expRx = (mSlaveQ.size() > 0) ? mSlaveQ.pop_front() : 16'h0;
              if (!cfgWide) expRx[15:8] = 8'h00;
              capCount++;
            end
          end
          trail = (cfgTrail > cfgHalf) ? int'(cfgTrail) : int'(cfgHalf);
          repeat (trail + 1) tick();
          if (pendQ.size() > 0) w = pendQ.pop_front();
          else more = 0;
        end
        expSsN = 1;
        repeat (int'(cfgIdle) + 1) tick();
        mBusy = 0;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && cmpOn) begin
      chk(sck === (expSckRaw ^ cfgCpol), "R7 R8 sck", int'(sck), int'(expSckRaw ^ cfgCpol));
      chk(ssN === expSsN, "R8 R9 R10 R11 ssN", int'(ssN), int'(expSsN));
      chk(mosi === expMosi, "R2 R3 mosi", int'(mosi), int'(expMosi));
      chk(rxData === expRx, "R4 rxData", int'(rxData), int'(expRx));
      chk(doneFlag === expDone, "R5 doneFlag", int'(doneFlag), int'(expDone));
      chk(overrun === expOvr, "R6 overrun", int'(overrun), int'(expOvr));
      chk(busy === (mBusy || pendQ.size() > 0), "R8 busy", int'(busy),
          int'(mBusy || pendQ.size() > 0));
    end
  end

  // ---------------- slave model ----------------
  int sIdx = 0;
  int edgeTotal = 0;
  int ssRise = 0;
  logic [15:0] sWord = '0;
  logic [15:0] sRx = '0;

  always @(sck) begin
    if (slaveOn) begin
      int sn;
      sn = cfgWide ? 16 : 8;
      edgeTotal++;
      if (sck != cfgCpol) begin
        if (sIdx == 0) sWord = (slaveQ.size() > 0) ? slaveQ.pop_front() : 16'h0;
        miso = cfgLsbFirst ? sWord[sIdx] : sWord[sn-1-sIdx];
      end else begin
        if (sIdx == 0) sRx = '0;
        if (cfgLsbFirst) sRx[sIdx] = mosi;
        else             sRx[sn-1-sIdx] = mosi;
        sIdx++;
        if (sIdx == sn) begin
          slaveRxQ.push_back(sRx);
          sIdx = 0;
        end
      end
    end
  end

  always @(posedge ssN) if (slaveOn) ssRise++;

  // ---------------- stimulus tasks ----------------
  task automatic setCfg(input bit pol, input bit lsb, input bit wide, input bit ss,
                        input int half, input int lead, input int trail, input int idle);
    @(negedge clk);
    slaveOn = 0;
    cfgCpol = pol; cfgLsbFirst = lsb; cfgWide = wide; cfgAutoSs = ss;
    cfgHalf = 8'(half); cfgLead = 8'(lead); cfgTrail = 8'(trail); cfgIdle = 8'(idle);
    sIdx = 0;
    @(negedge clk);
    slaveOn = 1;
  endtask

  task automatic writeTx(input logic [15:0] m, input logic [15:0] s);
    slaveQ.push_back(s);
    mSlaveQ.push_back(s);
    masterQ.push_back(cfgWide ? m : {8'h00, m[7:0]});
    @(negedge clk);
    txWrite = 1; txData = m;
    @(negedge clk);
    txWrite = 0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (mBusy || pendQ.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic readRx(input logic [15:0] exp);
    chk(rxData === exp, "R3 R4 received word", int'(rxData), int'(exp));
    rxRead = 1;
    @(negedge clk);
    rxRead = 0;
    chk(doneFlag === 1'b0, "R5 cleared by read", int'(doneFlag), 0);
  endtask

  task automatic checkSlave();
    while (masterQ.size() > 0) begin
      logic [15:0] m;
      m = masterQ.pop_front();
      if (slaveRxQ.size() > 0)
        chk(slaveRxQ.pop_front() === m, "R3 R1 slave got word", 0, int'(m));
      else
        chk(1'b0, "R1 slave word missing", 0, int'(m));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    int e0, r0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R12 reset state
    chk(sck === 1'b0, "R12 sck idle", int'(sck), 0);
    chk(ssN === 1'b1, "R12 ssN", int'(ssN), 1);
    chk(mosi === 1'b0, "R12 mosi", int'(mosi), 0);
    chk(doneFlag === 1'b0, "R12 doneFlag", int'(doneFlag), 0);
    chk(overrun === 1'b0, "R12 overrun", int'(overrun), 0);
    chk(rxData === 16'h0, "R12 rxData", int'(rxData), 0);
    chk(busy === 1'b0, "R12 busy", int'(busy), 0);
    cmpOn = 1;

    // 8-bit, MSB first, polarity 0
    setCfg(0, 0, 0, 1, 1, 2, 0, 3);
    e0 = edgeTotal;
    writeTx(16'h00A5, 16'h003C);
    waitIdle();
    chk(edgeTotal - e0 == 16, "R1 edges 8-bit", edgeTotal - e0, 16);
    readRx(16'h003C);
    checkSlave();

    // 16-bit, LSB first, polarity 1, back-to-back with overrun
    setCfg(1, 1, 1, 1, 2, 0, 5, 1);
    e0 = edgeTotal; r0 = ssRise;
    writeTx(16'h1234, 16'hBEEF);
    repeat (6) @(negedge clk);
    writeTx(16'h8001, 16'h7E55);
    waitIdle();
    chk(edgeTotal - e0 == 64, "R1 edges 16-bit pair", edgeTotal - e0, 64);
    chk(ssRise - r0 == 1, "R10 select held between words", ssRise - r0, 1);
    chk(overrun === 1'b1, "R6 overrun set", int'(overrun), 1);
    readRx(16'h7E55);
    chk(overrun === 1'b0, "R6 overrun cleared", int'(overrun), 0);
    checkSlave();

    // 8-bit, LSB first, select off, divide by two
    setCfg(0, 1, 0, 0, 0, 1, 2, 0);
    e0 = edgeTotal; r0 = ssRise;
    writeTx(16'hFFC3, 16'h0096);
    waitIdle();
    chk(edgeTotal - e0 == 16, "R1 edges fast", edgeTotal - e0, 16);
    chk(ssRise - r0 == 0 && ssN === 1'b1, "R11 select stays high", int'(ssN), 1);
    readRx(16'h0096);
    checkSlave();

    // 16-bit, MSB first, polarity 1, back-to-back, slow clock
    setCfg(1, 0, 1, 1, 3, 3, 1, 2);
    e0 = edgeTotal; r0 = ssRise;
    writeTx(16'hC0DE, 16'h5AA5);
    repeat (10) @(negedge clk);
    writeTx(16'h0F0F, 16'h9001);
    waitIdle();
    chk(edgeTotal - e0 == 64, "R1 edges slow pair", edgeTotal - e0, 64);
    chk(ssRise - r0 == 1, "R10 chained words", ssRise - r0, 1);
    readRx(16'h9001);
    checkSlave();

    // 8-bit, MSB first, polarity 1, short idle then second single word
    setCfg(1, 0, 0, 1, 0, 0, 0, 0);
    writeTx(16'h0081, 16'h00E7);
    waitIdle();
    readRx(16'h00E7);
    writeTx(16'h007E, 16'h0011);
    waitIdle();
    readRx(16'h0011);
    checkSlave();

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule